// File: doc/BRIEF.md
# Port Duplex and Negotiation Controller

This block governs one Ethernet port's operating mode and drives its status lines. A single duplex-select input carries two meanings. With the negotiation select low, it forces the port into full or half duplex. With the negotiation select high, it instead chooses which abilities the port offers to its link partner, and the operating duplex comes from the outcome of negotiation.

The code-word exchange itself is outside this block. It is represented by a done pulse, a fail pulse and the partner's ability pair. From the resolved mode the block also produces four status outputs:

- a collision flag, which is held quiet in full duplex;
- a jabber flag for transmit-enable runs that last too long;
- a negotiation-success status;
- an active-low link indicator.

Top module: `port_duplex_ctrl`

## Requirements
- R1: With `aneg_sel_i` low, `duplex_o` equals `dup_sel_i` in the same cycle (1 = full, 0 = half), and `aneg_ok_o` is low.
- R2: `adv_abil_o` bit 1 is full-duplex ability and bit 0 is half-duplex ability. With `aneg_sel_i` high it is `{dup_sel_i, 1}`. With `aneg_sel_i` low it is `2'b00`.
- R3: With `aneg_sel_i` high, before any completion pulse, `duplex_o` is low and `aneg_ok_o` is low.
- R4: A cycle sampling `an_done_i` high (with `aneg_sel_i` high, `an_fail_i` low and `lp_abil_i` nonzero) sets `aneg_ok_o` from the next cycle on. `duplex_o` then becomes high only if `dup_sel_i` and `lp_abil_i[1]` were both high in that cycle; otherwise it stays low. `lp_abil_i` uses the same bit order as `adv_abil_o`.
- R5: Each of the following leaves `aneg_ok_o` low and `duplex_o` low: a sampled `an_fail_i`, a done pulse arriving together with a fail pulse, or a done pulse with `lp_abil_i == 2'b00`. Taking `aneg_sel_i` low discards any result.
- R6: `coll_o` is high in the cycle after a sample in which `duplex_o` was low and `tx_en_i` and `rx_crs_i` were both high; otherwise it is low. In full duplex it never asserts.
- R7: `link_led_n_o` is the inverse of `link_ok_i`, registered by one cycle.
- R8: `jabber_o` rises after `JAB_LIMIT` consecutive cycles sampling `tx_en_i` high.
- R9: Once set, `jabber_o` clears after `UNJAB_LIMIT` consecutive cycles sampling `tx_en_i` low. Any high sample restarts that count.
- R10: During and right after reset, `coll_o` and `jabber_o` are low, `link_led_n_o` is high, and no negotiation result is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aneg_sel_i | input | 1 | Negotiation enable |
| dup_sel_i | input | 1 | Forced duplex, or full-duplex offer when negotiating |
| an_done_i | input | 1 | Negotiation completed pulse |
| an_fail_i | input | 1 | Negotiation failed pulse |
| lp_abil_i | input | 2 | Partner abilities {full, half} |
| tx_en_i | input | 1 | Transmit enable |
| rx_crs_i | input | 1 | Receive carrier present |
| link_ok_i | input | 1 | Link functioning |
| adv_abil_o | output | 2 | Advertised abilities {full, half} |
| duplex_o | output | 1 | 1 = full duplex |
| aneg_ok_o | output | 1 | Negotiation succeeded |
| coll_o | output | 1 | Collision present |
| jabber_o | output | 1 | Jabber condition |
| link_led_n_o | output | 1 | Link LED, active low |

## Verification
The bench builds the block with `JAB_LIMIT = 8` and `UNJAB_LIMIT = 12`. With these values, both edges of the jabber window are observed to the exact cycle, which the default multi-millisecond limits would make impractical. The same short limits also allow an interrupted release run to be shown restarting the release count. All negotiation outcomes use the same small limits: forced mode, partner with and without full duplex, a simultaneous done and fail, and an empty partner set.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        AN_WAIT = 2'd0,
        AN_OK   = 2'd1,
        AN_FAIL = 2'd2
    } an_state_e;

    typedef struct packed {
        logic full;
        logic half;
    } abil_t;

    function automatic abil_t offer(input logic neg_on, input logic want_full);
        abil_t a;
        a.full = neg_on & want_full;
        a.half = neg_on;
        return a;
    endfunction

    function automatic logic pick_full(input abil_t mine, input abil_t theirs);
        return mine.full & theirs.full;
    endfunction

endpackage

// File: rtl/pdc_neg.sv
module pdc_neg
    import pdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       aneg_sel,
    input  logic       dup_sel,
    input  logic       an_done,
    input  logic       an_fail,
    input  logic [1:0] lp_abil,
    output logic [1:0] adv_abil,
    output logic       duplex,
    output logic       aneg_ok
);
    an_state_e st_q;
    logic      full_q;
    abil_t     mine;
    abil_t     theirs;

    assign mine     = offer(aneg_sel, dup_sel);
    assign theirs   = abil_t'(lp_abil);
    assign adv_abil = mine;

    always_ff @(posedge clk) begin
        if (rst || !aneg_sel) begin
            st_q   <= AN_WAIT;
            full_q <= 1'b0;
        end else if (an_fail || (an_done && theirs == abil_t'(2'b00))) begin
            st_q   <= AN_FAIL;
            full_q <= 1'b0;
        end else if (an_done) begin
            st_q   <= AN_OK;
            full_q <= pick_full(mine, theirs);
        end
    end

    assign aneg_ok = aneg_sel && (st_q == AN_OK);
    assign duplex  = aneg_sel ? (aneg_ok && full_q) : dup_sel;
endmodule

// File: rtl/pdc_jabber.sv
module pdc_jabber #(
    parameter int JAB_LIMIT   = 400000,
    parameter int UNJAB_LIMIT = 10000000
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    output logic jabber
);
    localparam int CMAX = (JAB_LIMIT > UNJAB_LIMIT) ? JAB_LIMIT : UNJAB_LIMIT;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] JAB_LAST   = CW'(JAB_LIMIT - 1);
    localparam logic [CW-1:0] UNJAB_LAST = CW'(UNJAB_LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          jab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            jab_q <= 1'b0;
        end else if (!jab_q) begin
            if (!tx_en) begin
                cnt_q <= '0;
            end else if (cnt_q == JAB_LAST) begin
                cnt_q <= '0;
                jab_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (tx_en) begin
                cnt_q <= '0;
            end else if (cnt_q == UNJAB_LAST) begin
                cnt_q <= '0;
                jab_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign jabber = jab_q;
endmodule

// File: rtl/pdc_status.sv
module pdc_status (
    input  logic clk,
    input  logic rst,
    input  logic duplex,
    input  logic tx_en,
    input  logic rx_crs,
    input  logic link_ok,
    output logic coll,
    output logic led_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            coll  <= 1'b0;
            led_n <= 1'b1;
        end else begin
            coll  <= !duplex && tx_en && rx_crs;
            led_n <= !link_ok;
        end
    end
endmodule

// File: rtl/port_duplex_ctrl.sv
module port_duplex_ctrl #(
    parameter int JAB_LIMIT   = 400000,
    parameter int UNJAB_LIMIT = 10000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       aneg_sel_i,
    input  logic       dup_sel_i,
    input  logic       an_done_i,
    input  logic       an_fail_i,
    input  logic [1:0] lp_abil_i,
    input  logic       tx_en_i,
    input  logic       rx_crs_i,
    input  logic       link_ok_i,
    output logic [1:0] adv_abil_o,
    output logic       duplex_o,
    output logic       aneg_ok_o,
    output logic       coll_o,
    output logic       jabber_o,
    output logic       link_led_n_o
);
    logic dup_w;

    pdc_neg i_neg (
        .clk      (clk),
        .rst      (rst),
        .aneg_sel (aneg_sel_i),
        .dup_sel  (dup_sel_i),
        .an_done  (an_done_i),
        .an_fail  (an_fail_i),
        .lp_abil  (lp_abil_i),
        .adv_abil (adv_abil_o),
        .duplex   (dup_w),
        .aneg_ok  (aneg_ok_o)
    );

    pdc_jabber #(
        .JAB_LIMIT   (JAB_LIMIT),
        .UNJAB_LIMIT (UNJAB_LIMIT)
    ) i_jab (
        .clk    (clk),
        .rst    (rst),
        .tx_en  (tx_en_i),
        .jabber (jabber_o)
    );

    pdc_status i_stat (
        .clk     (clk),
        .rst     (rst),
        .duplex  (dup_w),
        .tx_en   (tx_en_i),
        .rx_crs  (rx_crs_i),
        .link_ok (link_ok_i),
        .coll    (coll_o),
        .led_n   (link_led_n_o)
    );

    assign duplex_o = dup_w;
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker (
    input logic       clk,
    input logic       rst,
    input logic       aneg_sel_i,
    input logic       dup_sel_i,
    input logic       an_done_i,
    input logic       an_fail_i,
    input logic [1:0] lp_abil_i,
    input logic       tx_en_i,
    input logic       rx_crs_i,
    input logic       link_ok_i,
    input logic [1:0] adv_abil_o,
    input logic       duplex_o,
    input logic       aneg_ok_o,
    input logic       coll_o,
    input logic       jabber_o,
    input logic       link_led_n_o
);
    // R2: negotiating always offers half duplex
    a_r2_half_offered: assert property (@(posedge clk) disable iff (rst)
        aneg_sel_i |-> adv_abil_o[0]);

    // R2: the full-duplex offer bit follows the duplex select
    a_r2_full_offer: assert property (@(posedge clk) disable iff (rst)
        aneg_sel_i |-> (adv_abil_o[1] == dup_sel_i));

    // R4: full duplex under negotiation only after success
    a_r4_full_needs_ok: assert property (@(posedge clk) disable iff (rst)
        (aneg_sel_i && duplex_o) |-> aneg_ok_o);

    // R4/R5: success rises only after a clean done pulse with a nonempty partner set
    a_r5_ok_source: assert property (@(posedge clk) disable iff (rst)
        $rose(aneg_ok_o) |-> (aneg_sel_i && $past(an_done_i) && !$past(an_fail_i)
                              && ($past(lp_abil_i) != 2'b00)));

    // R6: no collision after a full-duplex cycle
    a_r6_full_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(duplex_o) |-> !coll_o);

    // R6: a collision needs transmit and carrier together
    a_r6_coll_cause: assert property (@(posedge clk) disable iff (rst)
        coll_o |-> ($past(tx_en_i) && $past(rx_crs_i)));

    // R7: the LED follows the link one cycle later
    a_r7_led: assert property (@(posedge clk) disable iff (rst)
        link_ok_i |=> !link_led_n_o);

    // R8: jabber rises only during transmit
    a_r8_jab_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(jabber_o) |-> $past(tx_en_i));

    // R9: jabber falls only after an idle sample
    a_r9_jab_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(jabber_o) |-> !$past(tx_en_i));
endmodule

bind port_duplex_ctrl pdc_checker i_chk (.*);

// File: tb/test_port_duplex_ctrl.sv
module test_port_duplex_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       aneg_sel_i = 1'b0, dup_sel_i = 1'b0, an_done_i = 1'b0, an_fail_i = 1'b0;
    logic [1:0] lp_abil_i = 2'b00;
    logic       tx_en_i = 1'b0, rx_crs_i = 1'b0, link_ok_i = 1'b0;
    logic [1:0] adv_abil_o;
    logic       duplex_o, aneg_ok_o, coll_o, jabber_o, link_led_n_o;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    port_duplex_ctrl #(.JAB_LIMIT(8), .UNJAB_LIMIT(12)) i_port_duplex_ctrl (.*);

    // forced-mode rows: {dup_sel, tx_en, rx_crs, link_ok, exp_duplex, exp_coll, exp_led_n}
    localparam int NV = 8;
    localparam logic [6:0] VEC [NV] = '{
        7'b0111_010,
        7'b0101_000,
        7'b0010_001,
        7'b1111_100,
        7'b1000_101,
        7'b0110_011,
        7'b1111_100,
        7'b0001_000
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic done_pulse(input logic fail);
        an_done_i = 1'b1;
        an_fail_i = fail;
        tick(1);
        an_done_i = 1'b0;
        an_fail_i = 1'b0;
    endtask

    task automatic restart_neg(input logic dsel, input logic [1:0] lp);
        aneg_sel_i = 1'b0;
        tick(1);
        aneg_sel_i = 1'b1;
        dup_sel_i  = dsel;
        lp_abil_i  = lp;
        tick(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R10 reset state
        chk("R10 coll", coll_o, 0);
        chk("R10 jabber", jabber_o, 0);
        chk("R10 led", link_led_n_o, 1);
        chk("R10 aneg_ok", aneg_ok_o, 0);
        rst = 1'b0;
        tick(1);
        chk("R10 led after release", link_led_n_o, 1);

        // forced mode table (R1, R6, R7)
        for (int k = 0; k < NV; k++) begin
            dup_sel_i = VEC[k][6];
            tx_en_i   = VEC[k][5];
            rx_crs_i  = VEC[k][4];
            link_ok_i = VEC[k][3];
            tick(1);
            chk("R1 duplex", duplex_o, VEC[k][2]);
            chk("R6 coll", coll_o, VEC[k][1]);
            chk("R7 led", link_led_n_o, VEC[k][0]);
        end
        chk("R1 aneg_ok low", aneg_ok_o, 0);
        chk("R2 adv off", adv_abil_o, 2'b00);
        tx_en_i = 1'b0;
        rx_crs_i = 1'b0;

        // negotiation pending (R2, R3)
        restart_neg(1'b1, 2'b11);
        chk("R2 adv both", adv_abil_o, 2'b11);
        chk("R3 pending duplex", duplex_o, 0);
        chk("R3 pending ok", aneg_ok_o, 0);

        // both full (R4), then full-duplex collision silence (R6)
        done_pulse(1'b0);
        chk("R4 ok", aneg_ok_o, 1);
        chk("R4 full", duplex_o, 1);
        tx_en_i = 1'b1;
        rx_crs_i = 1'b1;
        tick(2);
        chk("R6 full no coll", coll_o, 0);
        tx_en_i = 1'b0;
        rx_crs_i = 1'b0;

        // partner half only (R4)
        restart_neg(1'b1, 2'b01);
        done_pulse(1'b0);
        chk("R4 partner half ok", aneg_ok_o, 1);
        chk("R4 partner half duplex", duplex_o, 0);

        // local half only (R4, R2)
        restart_neg(1'b0, 2'b11);
        chk("R2 adv half", adv_abil_o, 2'b01);
        done_pulse(1'b0);
        chk("R4 local half ok", aneg_ok_o, 1);
        chk("R4 local half duplex", duplex_o, 0);

        // done and fail together (R5)
        restart_neg(1'b1, 2'b11);
        done_pulse(1'b1);
        chk("R5 fail wins ok", aneg_ok_o, 0);
        chk("R5 fail wins duplex", duplex_o, 0);

        // empty partner set (R5)
        restart_neg(1'b1, 2'b00);
        done_pulse(1'b0);
        chk("R5 empty partner", aneg_ok_o, 0);

        // dropping select discards success (R5, R1)
        restart_neg(1'b1, 2'b11);
        done_pulse(1'b0);
        aneg_sel_i = 1'b0;
        dup_sel_i = 1'b0;
        tick(1);
        chk("R5 drop select ok", aneg_ok_o, 0);
        aneg_sel_i = 1'b1;
        dup_sel_i = 1'b1;
        tick(1);
        chk("R5 reselect pending", aneg_ok_o, 0);
        chk("R5 reselect duplex", duplex_o, 0);

        // jabber (R8, R9)
        tick(2);
        tx_en_i = 1'b1;
        tick(7);
        chk("R8 before limit", jabber_o, 0);
        tick(1);
        chk("R8 at limit", jabber_o, 1);
        tx_en_i = 1'b0;
        tick(5);
        tx_en_i = 1'b1;
        tick(1);
        tx_en_i = 1'b0;
        tick(11);
        chk("R9 restarted hold", jabber_o, 1);
        tick(1);
        chk("R9 released", jabber_o, 0);

        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule